// File: doc/BRIEF.md
# Four-Lane Parallel Sine Tone Generator

This block synthesizes a digital sine tone at four samples per clock so that a converter consuming several samples per stream beat can run at four times the fabric clock. A single phase accumulator is shared by four lanes. Each lane adds its own multiple of the phase step, so the four lanes produce four time-consecutive samples of one waveform. Each lane turns its phase into a signed 16-bit amplitude through a quarter-wave sine table with symmetry folding. The four samples are packed into one 64-bit word and sent out on a valid/ready stream master.

The tone frequency is set by the `phase_step` input, which is the phase advance per sample in units of 2^-32 of a cycle. With a 153.6 MHz stream clock the sample rate is 614.4 MS/s, and a step of 104857600 gives a 15 MHz tone. A consumer unpacks the word and sign-extends each 16-bit field.

Back-pressure follows the usual stream rules. A word, once presented, stays on `m_tdata` unchanged with `m_tvalid` high until a cycle in which `m_tready` is high. The output register loads a new word whenever it is empty or its word is being accepted. It loads only while `enable` is high. The phase advances only when a word is loaded.

Top module: `tone_lanes_gen`

## Requirements
- R1: While `rst_n` is low, and on the first sampling after it, `m_tvalid` is 0, `m_tdata` is 0 and the phase accumulator is 0. The first word after reset therefore starts at phase 0.
- R2: The word loaded while the accumulator holds P with step S carries lane k phase (P + k*S) mod 2^32. The accumulator then becomes (P + 4*S) mod 2^32.
- R3: A lane sample depends only on a = phase[31:22]. Its value is 32767*sin(2*pi*(a+0.5)/1024), rounded to the nearest integer with halves away from zero.
- R4: Samples are 16-bit two's complement. Lane k (k = 0 is the earliest in time) occupies `m_tdata[16k+15:16k]`.
- R5: No lane ever carries -32768. Every sample lies in -32767..32767.
- R6: While `m_tvalid` is 1 and `m_tready` is 0, the next cycle keeps `m_tvalid` at 1 and `m_tdata` unchanged, and the accumulator does not move.
- R7: If the output is empty and `enable` is 1, a word appears in the next cycle even if `m_tready` is 0. Lowering `enable` never withdraws a presented word. Once that word is accepted with `enable` at 0, `m_tvalid` goes to 0 and stays 0 until `enable` returns.
- R8: A new `phase_step` value is used from the next word loaded onward, both for lane offsets and for the accumulator advance. It does not reset the phase, and it does not alter a word that is held under back-pressure.
- R9: With `enable` and `m_tready` held at 1, a new word is accepted every cycle with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows new words to be produced |
| phase_step | input | 32 | Per-sample phase increment, 2^-32 cycle units |
| m_tdata | output | 64 | Four packed signed samples, lane 0 in the low bits |
| m_tvalid | output | 1 | Word on m_tdata is valid |
| m_tready | input | 1 | Downstream accepts the word this cycle |

## Verification
Two events can land in the same cycle: a change of `phase_step` and a back-pressure stall. The bench changes the step while the word is held with ready low. The held word must stay bit-identical. The new step must then show up in the lane offsets and the phase advance of the first word loaded after release, continuing from the unreset phase. Enable drops that coincide with a stall, and with an acceptance, are judged in the same way against a cycle model of the accumulator built from the requirements.

// File: rtl/tone_gen_pkg.sv
package tone_gen_pkg;

  // Quadrant of the full sine cycle, taken from the two top phase bits.
  typedef enum logic [1:0] {
    QD_RISE  = 2'd0,
    QD_FALL  = 2'd1,
    QD_NRISE = 2'd2,
    QD_NFALL = 2'd3
  } quadrant_e;

  localparam real HALF_PI = 1.5707963267948966;

  // Magnitude stored at one quarter-wave table entry; the half-step offset
  // keeps the folded quadrants exactly symmetric.
  function automatic int quarter_mag(input int idx, input int depth, input int amp);
    real ang;
    real v;
    ang = HALF_PI * (real'(idx) + 0.5) / real'(depth);
    v   = real'(amp) * $sin(ang);
    return $rtoi(v + 0.5);
  endfunction

endpackage

// File: rtl/tone_phase_acc.sv
module tone_phase_acc #(
  parameter int PHASE_W = 32,
  parameter int LANES   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [PHASE_W-1:0] step,
  output logic [PHASE_W-1:0] base
);

  localparam logic [PHASE_W-1:0] LANES_V = PHASE_W'(LANES);

  logic [PHASE_W-1:0] stride;

  // One output word spans LANES samples of phase.
  assign stride = LANES_V * step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0;
    end else if (load) begin
      base <= base + stride;
    end
  end

endmodule

// File: rtl/tone_lane_phases.sv
module tone_lane_phases #(
  parameter int PHASE_W = 32,
  parameter int LANES   = 4,
  parameter int ADDR_W  = 10
) (
  input  logic [PHASE_W-1:0]             base,
  input  logic [PHASE_W-1:0]             step,
  output logic [LANES-1:0][ADDR_W-1:0]   lane_addr
);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [PHASE_W-1:0] K_V = PHASE_W'(k);
    logic [PHASE_W-1:0] full_phase;
    logic               unused_low;

    assign full_phase   = base + K_V * step;
    assign lane_addr[k] = full_phase[PHASE_W-1 -: ADDR_W];
    assign unused_low   = ^full_phase[PHASE_W-ADDR_W-1:0];
  end

endmodule

// File: rtl/tone_sine_lut.sv
module tone_sine_lut
  import tone_gen_pkg::*;
#(
  parameter int QTR_W  = 8,
  parameter int SAMP_W = 16
) (
  input  logic [QTR_W+1:0]          addr,
  output logic signed [SAMP_W-1:0]  sample
);

  localparam int DEPTH = 1 << QTR_W;
  localparam int AMP   = (1 << (SAMP_W - 1)) - 1;

  logic [SAMP_W-2:0] rom [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_rom
    localparam int MAG = quarter_mag(gi, DEPTH, AMP);
    assign rom[gi] = (SAMP_W-1)'(MAG);
  end

  quadrant_e                quad;
  logic [QTR_W-1:0]         idx;
  logic [QTR_W-1:0]         rd_idx;
  logic [SAMP_W-2:0]        mag;
  logic signed [SAMP_W-1:0] pos;

  assign quad = quadrant_e'(addr[QTR_W+1:QTR_W]);
  assign idx  = addr[QTR_W-1:0];

  // Second and fourth quadrants read the table backwards.
  always_comb begin
    case (quad)
      QD_FALL, QD_NFALL: rd_idx = ~idx;
      default:           rd_idx = idx;
    endcase
  end

  assign mag = rom[rd_idx];
  assign pos = signed'({1'b0, mag});

  // Lower half cycle is the negated upper half.
  always_comb begin
    case (quad)
      QD_NRISE, QD_NFALL: sample = -pos;
      default:            sample = pos;
    endcase
  end

endmodule

// File: rtl/tone_word_reg.sv
module tone_word_reg #(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [WORD_W-1:0] word_in,
  output logic              load,
  output logic [WORD_W-1:0] tdata,
  output logic              tvalid,
  input  logic              tready
);

  logic slot_free;

  assign slot_free = !tvalid || tready;
  assign load      = enable && slot_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tvalid <= 1'b0;
      tdata  <= '0;
    end else if (slot_free) begin
      tvalid <= enable;
      if (enable) begin
        tdata <= word_in;
      end
    end
  end

endmodule

// File: rtl/tone_lanes_gen.sv
module tone_lanes_gen #(
  parameter int PHASE_W = 32,
  parameter int LANES   = 4,
  parameter int SAMP_W  = 16,
  parameter int QTR_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enable,
  input  logic [PHASE_W-1:0]        phase_step,
  output logic [LANES*SAMP_W-1:0]   m_tdata,
  output logic                      m_tvalid,
  input  logic                      m_tready
);

  localparam int ADDR_W = QTR_W + 2;
  localparam int WORD_W = LANES * SAMP_W;

  logic                           load;
  logic [PHASE_W-1:0]             base;
  logic [LANES-1:0][ADDR_W-1:0]   lane_addr;
  logic [WORD_W-1:0]              word;

  tone_phase_acc #(
    .PHASE_W (PHASE_W),
    .LANES   (LANES)
  ) acc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .step  (phase_step),
    .base  (base)
  );

  tone_lane_phases #(
    .PHASE_W (PHASE_W),
    .LANES   (LANES),
    .ADDR_W  (ADDR_W)
  ) phases_i (
    .base      (base),
    .step      (phase_step),
    .lane_addr (lane_addr)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_sine
    logic signed [SAMP_W-1:0] lane_sample;

    tone_sine_lut #(
      .QTR_W  (QTR_W),
      .SAMP_W (SAMP_W)
    ) lut_i (
      .addr   (lane_addr[k]),
      .sample (lane_sample)
    );

    // Earliest sample in the lowest field.
    assign word[k*SAMP_W +: SAMP_W] = lane_sample;
  end

  tone_word_reg #(
    .WORD_W (WORD_W)
  ) out_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .word_in (word),
    .load    (load),
    .tdata   (m_tdata),
    .tvalid  (m_tvalid),
    .tready  (m_tready)
  );

endmodule

// File: rtl/tone_lanes_gen_chk.sv
module tone_lanes_gen_chk #(
  parameter int LANES  = 4,
  parameter int SAMP_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    enable,
  input logic [LANES*SAMP_W-1:0] m_tdata,
  input logic                    m_tvalid,
  input logic                    m_tready
);

  localparam logic [SAMP_W-1:0] MOST_NEG = {1'b1, {(SAMP_W-1){1'b0}}};

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata)); // R6

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    !m_tvalid && !enable |=> !m_tvalid); // R7

  AST_FILL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !m_tvalid && enable |=> m_tvalid); // R7

  AST_DRAIN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_tready && !enable |=> !m_tvalid); // R7

  AST_STREAM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_tready && enable |=> m_tvalid); // R9

  for (genvar k = 0; k < LANES; k++) begin : g_lim
    AST_NO_MOST_NEG: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid |-> m_tdata[k*SAMP_W +: SAMP_W] != MOST_NEG); // R5
  end

endmodule

bind tone_lanes_gen tone_lanes_gen_chk #(
  .LANES  (LANES),
  .SAMP_W (SAMP_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .m_tdata  (m_tdata),
  .m_tvalid (m_tvalid),
  .m_tready (m_tready)
);

// File: tb/tone_lanes_gen_tb_top.sv
module tone_lanes_gen_tb_top;

  localparam real PI = 3.14159265358979323846;
  localparam logic [31:0] STEP_15M = 32'd104857600;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [31:0] phase_step = STEP_15M;
  logic [63:0] m_tdata;
  logic        m_tvalid;
  logic        m_tready = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] ref_acc = '0;
  logic        exp_valid = 1'b0;
  logic [63:0] exp_data = '0;

  always #4 clk = ~clk;

  tone_lanes_gen dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .phase_step (phase_step),
    .m_tdata    (m_tdata),
    .m_tvalid   (m_tvalid),
    .m_tready   (m_tready)
  );

  // R3: sample from the ten top phase bits, rounded half away from zero.
  function automatic logic [15:0] ref_sample(input logic [31:0] ph);
    int  a;
    int  r;
    real x;
    a = int'(ph[31:22]);
    x = 32767.0 * $sin(2.0 * PI * (real'(a) + 0.5) / 1024.0);
    if (x >= 0.0) r = $rtoi(x + 0.5);
    else          r = -$rtoi(-x + 0.5);
    return 16'(r);
  endfunction

  // R2 and R4: lane k phase is P + k*S, lane k in bits [16k+15:16k].
  function automatic logic [63:0] ref_word(input logic [31:0] p, input logic [31:0] s);
    logic [63:0] w;
    for (int k = 0; k < 4; k++) begin
      w[k*16 +: 16] = ref_sample(p + 32'(k) * s);
    end
    return w;
  endfunction

  task automatic check_out(input string tag);
    checks++;
    if (m_tvalid !== exp_valid || (exp_valid && m_tdata !== exp_data)) begin
      errors++;
      $display("FAIL %s: tvalid/tdata actual %0b/%h expected %0b/%h",
               tag, m_tvalid, m_tdata, exp_valid, exp_data);
    end
  endtask

  task automatic check_range(input string tag);
    for (int k = 0; k < 4; k++) begin
      checks++;
      if (m_tdata[k*16 +: 16] == 16'h8000) begin
        errors++;
        $display("FAIL %s: lane %0d actual %h expected above 8000", tag, k, m_tdata[k*16 +: 16]);
      end
    end
  endtask

  // Drive at a falling edge, step the reference model, check at the next falling edge.
  task automatic cyc(input logic en, input logic rdy, input logic [31:0] stp, input string tag);
    enable     = en;
    m_tready   = rdy;
    phase_step = stp;
    if (!exp_valid || rdy) begin
      if (en) begin
        exp_data  = ref_word(ref_acc, stp);
        exp_valid = 1'b1;
        ref_acc   = ref_acc + 32'd4 * stp;
      end else begin
        exp_valid = 1'b0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check_out(tag);
  endtask

  task automatic do_reset(input string tag);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    exp_valid = 1'b0;
    exp_data  = '0;
    ref_acc   = '0;
    checks++;
    if (m_tvalid !== 1'b0 || m_tdata !== 64'h0) begin
      errors++;
      $display("FAIL %s: tvalid/tdata actual %0b/%h expected 0/0", tag, m_tvalid, m_tdata);
    end
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    do_reset("R1 initial");
    cyc(1'b0, 1'b1, STEP_15M, "R1 idle after reset");

    // R3 / R5: one table address per sample, whole cycle in 256 words.
    for (int i = 0; i < 256; i++) begin
      cyc(1'b1, 1'b1, 32'h0040_0000, "R3 sweep");
      check_range("R5 sweep");
    end

    // R2 / R6: default tone with a ready pattern that stalls every third cycle.
    for (int i = 0; i < 60; i++) begin
      cyc(1'b1, (i % 3) != 0, STEP_15M, "R6 stall pattern");
    end

    // R8: change the step while a word is held.
    cyc(1'b1, 1'b0, 32'h0123_4567, "R8 hold through step change");
    cyc(1'b1, 1'b0, 32'h0123_4567, "R8 still held");
    for (int i = 0; i < 6; i++) begin
      cyc(1'b1, 1'b1, 32'h0123_4567, "R8 new step applied");
    end

    // R7: enable drops with a word held, then on acceptance.
    cyc(1'b0, 1'b0, STEP_15M, "R7 held with enable low");
    cyc(1'b0, 1'b1, STEP_15M, "R7 drain");
    cyc(1'b0, 1'b1, STEP_15M, "R7 stays empty");
    cyc(1'b1, 1'b0, STEP_15M, "R7 fill while not ready");
    cyc(1'b1, 1'b0, STEP_15M, "R6 held after fill");

    // R9: continuous flow, with phase wrap from a large step (R2).
    for (int i = 0; i < 20; i++) begin
      cyc(1'b1, 1'b1, 32'hC000_0001, "R9 wrap stream");
    end

    // R2: zero step gives a frozen phase, all lanes equal.
    for (int i = 0; i < 4; i++) begin
      cyc(1'b1, 1'b1, 32'h0, "R2 zero step");
    end

    // R1: reset while a word is present, then restart from phase 0.
    cyc(1'b1, 1'b0, STEP_15M, "R6 before reset");
    do_reset("R1 mid-run");
    for (int i = 0; i < 8; i++) begin
      cyc(1'b1, 1'b1, STEP_15M, "R1 restart phase");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule